// File: doc/BRIEF.md
# Flat Nested Table Two-Level Translation Walker

This block translates a 48-bit guest virtual address into a system physical address for a virtual machine. The guest's own page table keeps its 4-level radix layout, while the hypervisor's guest-physical to system-physical mapping is held as one flat array of 8-byte entries. The array is indexed directly by the guest physical page number, starting from a nested base address. Any guest physical address the walk meets (the guest root pointer, each intermediate table pointer and the final data address) is mapped by exactly one read of that array. A full successful walk therefore costs 9 memory reads, with nested and guest reads strictly alternating.

A request carries the guest virtual address, the guest root pointer (a guest physical address) and the nested array base. The block accepts it when idle and issues one read at a time on its table-read port. Each read is answered by a single data beat. It ends with a one-cycle response that holds either the translated address or a fault code together with the guest physical address that caused the fault. Guest physical space is 4 GB with 4 KB pages, so the flat array has 2^20 entries (8 MB).

Top module: `fnw_walker`

## Requirements
- R1: After reset and between walks, `req_ready_o` is 1 and `mem_req_o` and `rsp_valid_o` are 0; `req_ready_o` is 0 while a walk is in progress.
- R2: A nested read for guest physical address G is issued at address `nest_base + G[31:12]*8`.
- R3: A successful walk issues exactly 9 reads. Reads 1, 3, 5, 7 and 9 are nested reads and reads 2, 4, 6 and 8 are guest reads.
- R4: Guest level L (3 first, down to 0) uses index `gva[12+9L +: 9]`. The entry's guest physical address is `{table_frame, index, 3'b000}`. The guest read goes to `{nested_frame, that address[11:0]}`.
- R5: Every table entry holds a present flag in bit 0 and a 40-bit frame number in bits [51:12]. A successful walk responds with fault code 0 and `{final nested frame, gva[11:0]}`.
- R6: A guest physical address with any bit at or above bit 32 set produces fault code 3. No nested read is issued for it, and the fault address output carries that address.
- R7: A nested entry with bit 0 clear produces fault code 2. The fault address output carries the guest physical address being mapped, and no further read follows.
- R8: A guest entry with bit 0 clear produces fault code 1. The fault address output carries that entry's guest physical address.
- R9: `rsp_valid_o` is a single-cycle pulse, and at most one read is outstanding: `mem_req_o` is a one-cycle pulse and is not raised again before `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_gva_i | input | 48 | Guest virtual address |
| guest_root_i | input | 52 | Guest physical address of the top guest table |
| nest_base_i | input | 52 | System physical base of the flat nested array |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_spa_o | output | 52 | Translated system physical address (0 on fault) |
| rsp_fault_o | output | 2 | 0 ok, 1 guest entry absent, 2 nested entry absent, 3 guest physical address out of range |
| rsp_fault_gpa_o | output | 52 | Guest physical address behind the fault (0 when ok) |
| mem_req_o | output | 1 | Table read request pulse |
| mem_addr_o | output | 52 | Table read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data (table entry) |

## Verification
The main function is swept over many pseudo-random guest virtual addresses and root pointers, plus the all-zero and all-one addresses. Each sweep point is checked against a bench-side walk of arithmetic table contents. Comparing the full read log at each point separates errors in index extraction per level from errors in nested addressing and in read ordering. Faults are then injected at each step of a traced walk, one step at a time: an absent nested entry, an absent guest entry and an out-of-range pointer. The read count and reported address at each step show whether the walk stops at the right read and blames the right guest physical address. A root pointer above 4 GB must fault with no read at all.

// File: rtl/fnw_pkg.sv
package fnw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_GUEST_NP = 2'd1,
    FLT_NEST_NP  = 2'd2,
    FLT_RANGE    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NREQ, ST_NWAIT, ST_GREQ, ST_GWAIT, ST_RESP
  } state_e;

  localparam int unsigned PTE_W = 64;
endpackage

// File: rtl/fnw_nest_addr.sv
module fnw_nest_addr #(
  parameter int unsigned PA_W   = 52,
  parameter int unsigned GPA_W  = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic [PA_W-1:0] nest_base_i,
  input  logic [PA_W-1:0] gpa_i,
  output logic [PA_W-1:0] nest_addr_o,
  output logic            gpa_oor_o
);
  localparam int unsigned GPPN_W = GPA_W - PAGE_W;

  logic [GPPN_W-1:0] gppn;
  assign gppn        = gpa_i[GPA_W-1:PAGE_W];
  assign nest_addr_o = nest_base_i + PA_W'({gppn, 3'b000});
  assign gpa_oor_o   = |gpa_i[PA_W-1:GPA_W];
endmodule

// File: rtl/fnw_pte_decode.sv
module fnw_pte_decode #(
  parameter int unsigned PA_W   = 52,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned PTE_W  = 64
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic                   present_o,
  output logic [PA_W-PAGE_W-1:0] frame_o
);
  assign present_o = pte_i[0];
  assign frame_o   = pte_i[PA_W-1:PAGE_W];
endmodule

// File: rtl/fnw_walk_ctrl.sv
module fnw_walk_ctrl
  import fnw_pkg::*;
#(
  parameter int unsigned GVA_W  = 48,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [GVA_W-1:0]       req_gva_i,
  input  logic [PA_W-1:0]        guest_root_i,
  input  logic [PA_W-1:0]        nest_base_i,
  output logic [PA_W-1:0]        nest_base_o,
  input  logic                   pte_present_i,
  input  logic [PA_W-PAGE_W-1:0] pte_frame_i,
  input  logic                   gpa_oor_i,
  input  logic                   mem_rvalid_i,
  output logic                   mem_req_o,
  output logic                   nest_phase_o,
  output logic [PA_W-1:0]        cur_gpa_o,
  output logic [PA_W-1:0]        guest_addr_o,
  output logic                   rsp_valid_o,
  output logic [PA_W-1:0]        rsp_spa_o,
  output logic [1:0]             rsp_fault_o,
  output logic [PA_W-1:0]        rsp_fault_gpa_o
);
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  state_e            state_q;
  fault_e            fault_q;
  logic [GVA_W-1:0]  gva_q;
  logic [PA_W-1:0]   nbase_q, cur_gpa_q, spa_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              final_q;

  // byte offset of the entry for level lvl inside its table page
  function automatic logic [PAGE_W-1:0] ent_ofs(input logic [GVA_W-1:0] gva,
                                                input logic [LVL_W-1:0] lvl);
    logic [IDX_W-1:0] idx;
    idx = gva[PAGE_W + IDX_W*lvl +: IDX_W];
    return PAGE_W'({idx, 3'b000});
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fault_q   <= FLT_NONE;
      gva_q     <= '0;
      nbase_q   <= '0;
      cur_gpa_q <= '0;
      spa_q     <= '0;
      lvl_q     <= '0;
      final_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          gva_q     <= req_gva_i;
          nbase_q   <= nest_base_i;
          cur_gpa_q <= {guest_root_i[PA_W-1:PAGE_W],
                        ent_ofs(req_gva_i, LVL_W'(LEVELS-1))};
          lvl_q     <= LVL_W'(LEVELS-1);
          final_q   <= 1'b0;
          fault_q   <= FLT_NONE;
          state_q   <= ST_NREQ;
        end
        ST_NREQ: begin
          if (gpa_oor_i) begin
            fault_q <= FLT_RANGE;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_NWAIT;
          end
        end
        ST_NWAIT: if (mem_rvalid_i) begin
          if (!pte_present_i) begin
            fault_q <= FLT_NEST_NP;
            state_q <= ST_RESP;
          end else begin
            spa_q   <= {pte_frame_i, cur_gpa_q[PAGE_W-1:0]};
            state_q <= final_q ? ST_RESP : ST_GREQ;
          end
        end
        ST_GREQ: state_q <= ST_GWAIT;
        ST_GWAIT: if (mem_rvalid_i) begin
          if (!pte_present_i) begin
            fault_q <= FLT_GUEST_NP;
            state_q <= ST_RESP;
          end else begin
            if (lvl_q == '0) begin
              cur_gpa_q <= {pte_frame_i, gva_q[PAGE_W-1:0]};
              final_q   <= 1'b1;
            end else begin
              cur_gpa_q <= {pte_frame_i, ent_ofs(gva_q, lvl_q - 1'b1)};
              lvl_q     <= lvl_q - 1'b1;
            end
            state_q <= ST_NREQ;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_o       = ((state_q == ST_NREQ) && !gpa_oor_i) || (state_q == ST_GREQ);
  assign nest_phase_o    = (state_q == ST_NREQ) || (state_q == ST_NWAIT);
  assign nest_base_o     = nbase_q;
  assign cur_gpa_o       = cur_gpa_q;
  assign guest_addr_o    = spa_q;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_fault_o     = fault_q;
  assign rsp_spa_o       = (fault_q == FLT_NONE) ? spa_q : '0;
  assign rsp_fault_gpa_o = (fault_q == FLT_NONE) ? '0 : cur_gpa_q;
endmodule

// File: rtl/fnw_walker.sv
module fnw_walker
  import fnw_pkg::*;
#(
  parameter int unsigned GVA_W  = 48,
  parameter int unsigned GPA_W  = 32,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [GVA_W-1:0] req_gva_i,
  input  logic [PA_W-1:0]  guest_root_i,
  input  logic [PA_W-1:0]  nest_base_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_spa_o,
  output logic [1:0]       rsp_fault_o,
  output logic [PA_W-1:0]  rsp_fault_gpa_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  localparam int unsigned FRAME_W = PA_W - PAGE_W;

  logic               pte_present, gpa_oor, nest_phase;
  logic [FRAME_W-1:0] pte_frame;
  logic [PA_W-1:0]    nbase, cur_gpa, guest_addr, nest_addr;

  fnw_walk_ctrl #(
    .GVA_W(GVA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_gva_i, .guest_root_i,
    .nest_base_i,
    .nest_base_o     (nbase),
    .pte_present_i   (pte_present),
    .pte_frame_i     (pte_frame),
    .gpa_oor_i       (gpa_oor),
    .mem_rvalid_i,
    .mem_req_o,
    .nest_phase_o    (nest_phase),
    .cur_gpa_o       (cur_gpa),
    .guest_addr_o    (guest_addr),
    .rsp_valid_o, .rsp_spa_o, .rsp_fault_o, .rsp_fault_gpa_o
  );

  fnw_nest_addr #(.PA_W(PA_W), .GPA_W(GPA_W), .PAGE_W(PAGE_W)) u_naddr (
    .nest_base_i (nbase),
    .gpa_i       (cur_gpa),
    .nest_addr_o (nest_addr),
    .gpa_oor_o   (gpa_oor)
  );

  fnw_pte_decode #(.PA_W(PA_W), .PAGE_W(PAGE_W), .PTE_W(PTE_W)) u_pte (
    .pte_i     (mem_rdata_i),
    .present_o (pte_present),
    .frame_o   (pte_frame)
  );

  assign mem_addr_o = nest_phase ? nest_addr : guest_addr;
endmodule

module fnw_walker_chk #(
  parameter int unsigned GPA_W  = 32,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned LEVELS = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_rvalid_i,
  input logic            rsp_valid_o,
  input logic [1:0]      rsp_fault_o,
  input logic [PA_W-1:0] rsp_fault_gpa_o,
  input logic            nest_phase
);
  logic       pend_q, exp_nest_q;
  logic [7:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      exp_nest_q <= 1'b1;
      rd_cnt_q   <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        exp_nest_q <= 1'b1;
        rd_cnt_q   <= '0;
      end else if (mem_req_o) begin
        exp_nest_q <= ~exp_nest_q;
        rd_cnt_q   <= rd_cnt_q + 8'd1;
      end
      if (mem_req_o)         pend_q <= 1'b1;
      else if (mem_rvalid_i) pend_q <= 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));
  // R2
  nest_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && nest_phase) |-> (mem_addr_o[2:0] == 3'b000));
  // R3
  alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (nest_phase == exp_nest_q));
  // R3
  read_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd0) |-> (rd_cnt_q == 8'(2*LEVELS+1)));
  // R6
  range_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd3) |-> (|rsp_fault_gpa_o[PA_W-1:GPA_W]));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);
endmodule

bind fnw_walker fnw_walker_chk #(.GPA_W(GPA_W), .PA_W(PA_W), .LEVELS(LEVELS)) chk_i (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .mem_req_o, .mem_addr_o,
  .mem_rvalid_i, .rsp_valid_o, .rsp_fault_o, .rsp_fault_gpa_o,
  .nest_phase (nest_phase)
);

// File: tb/fnw_walker_tb_top.sv
module fnw_walker_tb_top;
  localparam logic [51:0] NB    = 52'h80_0000_0000;
  localparam logic [39:0] SFOFS = 40'h10_0000;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [47:0] req_gva = '0;
  logic [51:0] root = '0, nbase = NB;
  logic        req_ready, rsp_valid, mem_req;
  logic [51:0] rsp_spa, rsp_fgpa, mem_addr;
  logic [1:0]  rsp_fault;
  logic        mem_rvalid = 0, pend = 0;
  logic [63:0] mem_rdata = '0;

  int errors = 0, checks = 0, cycles = 0;
  logic [20:0] np_gppn  = 21'h100000;
  logic [51:0] gnp_gpa  = '1;
  logic [51:0] oor_gpa  = '1;
  logic [51:0] rd_log [0:15];
  int          rd_n = 0;
  logic [51:0] tr_gpa [0:4];
  logic [51:0] e_spa, e_fgpa;
  logic [1:0]  e_fault;
  int          e_reads;

  fnw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_gva_i(req_gva), .guest_root_i(root), .nest_base_i(nbase),
    .rsp_valid_o(rsp_valid), .rsp_spa_o(rsp_spa), .rsp_fault_o(rsp_fault),
    .rsp_fault_gpa_o(rsp_fgpa), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [39:0] sframe(input logic [19:0] g);
    return SFOFS + 40'(g);
  endfunction

  function automatic logic [63:0] nest_entry(input logic [51:0] a);
    logic [51:0] g;
    g = (a - NB) >> 3;
    return {12'h0, sframe(g[19:0]), 11'h0, ({1'b0, g[19:0]} != np_gppn)};
  endfunction

  function automatic logic [63:0] guest_entry(input logic [51:0] a);
    logic [51:0] gpa;
    logic [39:0] fr;
    logic [28:0] h;
    gpa = {a[51:12] - SFOFS, a[11:0]};
    if (gpa == gnp_gpa) return 64'h0;
    h  = gpa[31:3] * 29'd13 + 29'd5;
    fr = (gpa == oor_gpa) ? 40'h10_0ABC : {20'h0, h[19:0]};
    return {12'h0, fr, 11'h0, 1'b1};
  endfunction

  // memory: data one cycle after the request cycle
  always @(negedge clk) begin
    cycles++;
    mem_rvalid <= pend;
    if (pend) mem_rdata <= (rd_log[rd_n-1] >= NB) ? nest_entry(rd_log[rd_n-1])
                                                  : guest_entry(rd_log[rd_n-1]);
    pend <= mem_req;
    if (mem_req) begin
      if (rd_n < 16) rd_log[rd_n] = mem_addr;
      rd_n++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ref_walk(input logic [47:0] gva, input logic [51:0] rt);
    logic [51:0] cur, spa;
    logic [63:0] e;
    cur = {rt[51:12], gva[12+27 +: 9], 3'b000};
    e_reads = 0; e_fault = 0; e_spa = 0; e_fgpa = 0;
    for (int s = 0; s < 5; s++) begin
      tr_gpa[s] = cur;
      if (cur[51:32] != 0) begin e_fault = 3; e_fgpa = cur; return; end
      e_reads++;
      if ({1'b0, cur[31:12]} == np_gppn) begin e_fault = 2; e_fgpa = cur; return; end
      spa = {sframe(cur[31:12]), cur[11:0]};
      if (s == 4) begin e_spa = spa; return; end
      e_reads++;
      e = guest_entry(spa);
      if (!e[0]) begin e_fault = 1; e_fgpa = cur; return; end
      if (s == 3) cur = {e[51:12], gva[11:0]};
      else        cur = {e[51:12], gva[12 + 9*(2-s) +: 9], 3'b000};
    end
  endtask

  task automatic run(input logic [47:0] gva, input logic [51:0] rt, input string tag);
    int w;
    ref_walk(gva, rt);
    @(negedge clk);
    rd_n = 0;
    req_gva = gva; root = rt; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check({"R1 busy ", tag}, req_ready, 0);
    w = 0;
    while (!rsp_valid && w < 200) begin @(negedge clk); w++; end
    check({"R5 fault ", tag}, rsp_fault, e_fault);
    check({"R5 spa ", tag}, rsp_spa, e_spa);
    check({"R7 fgpa ", tag}, rsp_fgpa, e_fgpa);
    check({"R3 reads ", tag}, rd_n, e_reads);
    if (e_reads > 0) check({"R2 first addr ", tag}, rd_log[0], NB + {tr_gpa[0][31:12], 3'b0});
    if (e_reads > 1) check({"R4 first guest ", tag}, rd_log[1], {sframe(tr_gpa[0][31:12]), tr_gpa[0][11:0]});
    for (int i = 0; i < rd_n && i < 16; i++)
      if ((rd_log[i] >= NB) != (i % 2 == 0)) check({"R3 order ", tag}, i, 99);
    @(negedge clk);
    check({"R9 pulse ", tag}, rsp_valid, 0);
    check({"R1 idle ", tag}, req_ready, 1);
  endtask

  initial begin
    logic [63:0] lcg;
    logic [47:0] g;
    logic [51:0] r;
    lcg = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready, 1);
    check("R1 reset req", mem_req, 0);
    check("R1 reset rsp", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    // sweep R3 R4 R5 R2
    for (int k = 0; k < 150; k++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      g = lcg[63:16];
      r = {20'h0, lcg[31:12], 12'h0};
      run(g, r, "sweep");
    end
    run(48'h0, 52'h0, "gva zero");
    run('1, 52'hFFFF_F000, "gva ones");
    // R6 root out of range: no read
    run(48'h1234_5678_9ABC, 52'h1_0000_0000, "R6 root");
    check("R6 no read", rd_n, 0);
    // walk-step injections on a traced walk
    g = 48'h7A5C_3E19_24F0; r = 52'h0_1234_5000;
    for (int s = 0; s < 5; s++) begin
      ref_walk(g, r);
      np_gppn = {1'b0, tr_gpa[s][31:12]};
      run(g, r, "R7 nest np");
      check("R7 code", rsp_fault, 2);
      np_gppn = 21'h100000;
    end
    for (int s = 0; s < 4; s++) begin
      ref_walk(g, r);
      gnp_gpa = tr_gpa[s];
      run(g, r, "R8 guest np");
      check("R8 code", rsp_fault, 1);
      check("R8 reads", rd_n, 2*s + 2);
      gnp_gpa = '1;
    end
    for (int s = 0; s < 4; s++) begin
      ref_walk(g, r);
      oor_gpa = tr_gpa[s];
      run(g, r, "R6 oor entry");
      check("R6 code", rsp_fault, 3);
      check("R6 fgpa high", {63'h0, |rsp_fgpa[51:32]}, 1);
      oor_gpa = '1;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule